// File: doc/BRIEF.md
# Bit Scan and Count Unit

This execution unit takes one source operand per issued operation and produces the new contents of a 64-bit destination register together with a zero flag and a carry flag. It supports four operations on a 32-bit or 64-bit operand: locating the highest set bit, locating the lowest set bit, counting leading zeros and counting trailing zeros. The issuing pipeline presents the opcode, the operand size, the source value and the current destination value with a valid strobe. The unit returns its registered result one clock later.

The two scan operations have no defined index when the source is zero. In that case the unit writes the old destination value back unchanged, all 64 bits of it, and raises the zero flag. The old value is preserved even in 32-bit mode, where a nonzero result would otherwise clear the upper half. The two count operations always give a defined answer: for a zero source they return the operand width and raise the carry flag. They never look at the old destination.

Top module: `bitscan_unit`

## Requirements
- R1: Opcode encoding is 0 = lowest-set-bit scan, 1 = highest-set-bit scan, 2 = leading-zero count, 3 = trailing-zero count. `isWide` = 1 selects a 64-bit operand and 0 selects a 32-bit operand, in which case source bits 63:32 are ignored.
- R2: The highest-set-bit scan of a nonzero source returns the bit index of its most significant 1, so a source of 1 gives 0.
- R3: The lowest-set-bit scan of a nonzero source returns the bit index of its least significant 1.
- R4: A scan with a nonzero source clears the zero flag and the carry flag, and zero-extends its index into all 64 destination bits.
- R5: A scan whose source is zero within the operand width sets the zero flag, clears the carry flag, and returns the full 64-bit old destination unchanged in both operand sizes.
- R6: The leading-zero count returns the number of zero bits above the highest 1 within the operand width. For a zero source it returns the width (32 or 64).
- R7: The trailing-zero count returns the number of zero bits below the lowest 1. For a zero source it returns the width.
- R8: For both counts, the carry flag is 1 exactly when the source is zero within the operand width, the zero flag is 1 exactly when the count is 0, the result is zero-extended to 64 bits, and the old destination value has no effect.
- R9: Result and flags update on the first rising clock edge at which `inValid` is high and hold their values while `inValid` is low.
- R10: A synchronous active-high reset clears the destination output and both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Operation issue strobe |
| opCode | input | 2 | Operation select (R1) |
| isWide | input | 1 | 1 = 64-bit operand, 0 = 32-bit |
| srcVal | input | 64 | Source operand |
| oldDest | input | 64 | Current destination register value |
| newDest | output | 64 | Registered destination result |
| zeroFlag | output | 1 | Registered zero flag |
| carryFlag | output | 1 | Registered carry flag |

## Verification
The bench focuses on zero sources in 32-bit scans with an all-ones old destination. A design that wrote back only the low half or zero-extended it would return 0x00000000_FFFFFFFF there. It also drives 32-bit sources whose only set bits lie above bit 31, which should behave as zero. A design that failed to mask them would report an index or count from the upper half. Counts of zero sources must give 32 or 64 with carry set, whatever garbage the old destination holds, and single-bit sources at bits 0, 31 and 63 expose off-by-one errors in the index-to-count conversion. Idle cycles with changing inputs catch outputs that do not hold.

// File: rtl/bsu_pkg.sv
package bsu_pkg;

  typedef enum logic [1:0] {
    OP_SCAN_LO  = 2'd0,
    OP_SCAN_HI  = 2'd1,
    OP_CNT_LEAD = 2'd2,
    OP_CNT_TRAIL = 2'd3
  } bsuOp_e;

  typedef struct packed {
    logic load;       // capture a new result this cycle
    logic countMode;  // 1 = count, 0 = scan
    logic fromTop;    // search starts at the most significant bit
    logic halfWidth;  // 32-bit operand
  } bsuStrobe_t;

endpackage

// File: rtl/bsu_ctrl.sv
module bsu_ctrl
  import bsu_pkg::*;
(
  input  logic       inValid,
  input  logic [1:0] opCode,
  input  logic       isWide,
  output bsuStrobe_t strobe
);

  bsuOp_e opDec;

  always_comb begin
    opDec = bsuOp_e'(opCode);
    strobe.load      = inValid;
    strobe.halfWidth = ~isWide;
    unique case (opDec)
      OP_SCAN_LO:   begin strobe.countMode = 1'b0; strobe.fromTop = 1'b0; end
      OP_SCAN_HI:   begin strobe.countMode = 1'b0; strobe.fromTop = 1'b1; end
      OP_CNT_LEAD:  begin strobe.countMode = 1'b1; strobe.fromTop = 1'b1; end
      default:      begin strobe.countMode = 1'b1; strobe.fromTop = 1'b0; end
    endcase
  end

endmodule

// File: rtl/bsu_datapath.sv
module bsu_datapath
  import bsu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  bsuStrobe_t        strobe,
  input  logic [DATA_W-1:0] srcVal,
  input  logic [DATA_W-1:0] oldDest,
  output logic [DATA_W-1:0] newDest,
  output logic              zeroFlag,
  output logic              carryFlag
);

  localparam int HALF_W = DATA_W / 2;
  localparam int IDX_W  = $clog2(DATA_W) + 1;

  logic [DATA_W-1:0] effSrc;
  logic [IDX_W-1:0]  hiIdx, loIdx, widthVal, scanIdx, countVal;
  logic              srcZero;
  logic [DATA_W-1:0] nextDest;
  logic              nextZf, nextCf;

  // Mask the operand to its size.
  always_comb begin
    effSrc = srcVal;
    if (strobe.halfWidth) effSrc[DATA_W-1:HALF_W] = '0;
  end

  assign srcZero  = (effSrc == '0);
  assign widthVal = strobe.halfWidth ? IDX_W'(HALF_W) : IDX_W'(DATA_W);

  // Position of the highest set bit.
  always_comb begin
    hiIdx = '0;
    for (int i = 0; i < DATA_W; i++)
      if (effSrc[i]) hiIdx = IDX_W'(i);
  end

  // Position of the lowest set bit.
  always_comb begin
    loIdx = '0;
    for (int i = DATA_W - 1; i >= 0; i--)
      if (effSrc[i]) loIdx = IDX_W'(i);
  end

  assign scanIdx = strobe.fromTop ? hiIdx : loIdx;

  always_comb begin
    if (srcZero)             countVal = widthVal;
    else if (strobe.fromTop) countVal = widthVal - IDX_W'(1) - hiIdx;
    else                     countVal = loIdx;
  end

  always_comb begin
    if (strobe.countMode) begin
      nextDest = DATA_W'(countVal);
      nextZf   = (countVal == '0);
      nextCf   = srcZero;
    end else if (srcZero) begin
      nextDest = oldDest;
      nextZf   = 1'b1;
      nextCf   = 1'b0;
    end else begin
      nextDest = DATA_W'(scanIdx);
      nextZf   = 1'b0;
      nextCf   = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      newDest   <= '0;
      zeroFlag  <= 1'b0;
      carryFlag <= 1'b0;
    end else if (strobe.load) begin
      newDest   <= nextDest;
      zeroFlag  <= nextZf;
      carryFlag <= nextCf;
    end
  end

  // A scan of a zero source hands back the old destination and sets ZF.
  assert_scan_zero_keeps_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(strobe.load) && $past(!strobe.countMode) && $past(srcZero))
      |-> (newDest == $past(oldDest) && zeroFlag && !carryFlag));

  // Idle cycles leave the outputs untouched.
  assert_idle_holds_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !$past(strobe.load))
      |-> ($stable(newDest) && $stable(zeroFlag) && $stable(carryFlag)));

  // Counts never exceed the operand width and carry marks a zero source.
  assert_count_bounded_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(strobe.load) && $past(strobe.countMode))
      |-> (newDest <= DATA_W'($past(widthVal))
           && (carryFlag == (newDest == DATA_W'($past(widthVal))))));

  // A 32-bit result that is not a preserved destination has a clear upper half.
  assert_half_zero_ext_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(strobe.load) && $past(strobe.halfWidth)
       && !($past(!strobe.countMode) && $past(srcZero)))
      |-> (newDest[DATA_W-1:HALF_W] == '0));

  // Carry is only ever raised by a count.
  assert_scan_no_carry_R4: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(strobe.load) && $past(!strobe.countMode)) |-> !carryFlag);

  // Reset clears every output.
  assert_reset_clears_R10: assert property (@(posedge clk)
    $past(rst) |-> (newDest == '0 && !zeroFlag && !carryFlag));

endmodule

// File: rtl/bitscan_unit.sv
module bitscan_unit #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [1:0]        opCode,
  input  logic              isWide,
  input  logic [DATA_W-1:0] srcVal,
  input  logic [DATA_W-1:0] oldDest,
  output logic [DATA_W-1:0] newDest,
  output logic              zeroFlag,
  output logic              carryFlag
);

  bsu_pkg::bsuStrobe_t strobe;

  bsu_ctrl u_ctrl (
    .inValid (inValid),
    .opCode  (opCode),
    .isWide  (isWide),
    .strobe  (strobe)
  );

  bsu_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .srcVal    (srcVal),
    .oldDest   (oldDest),
    .newDest   (newDest),
    .zeroFlag  (zeroFlag),
    .carryFlag (carryFlag)
  );

endmodule

// File: tb/bitscan_unit_tb.sv
`timescale 1ns/1ps
module bitscan_unit_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        inValid;
  logic [1:0]  opCode;
  logic        isWide;
  logic [63:0] srcVal, oldDest;
  logic [63:0] newDest;
  logic        zeroFlag, carryFlag;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 0;

  always #2.5 clk = ~clk;

  bitscan_unit u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .opCode(opCode), .isWide(isWide),
    .srcVal(srcVal), .oldDest(oldDest), .newDest(newDest),
    .zeroFlag(zeroFlag), .carryFlag(carryFlag)
  );

  // Reference model: {dest, zf, cf}
  function automatic logic [65:0] model(input logic [1:0] op, input logic wide,
                                        input logic [63:0] src, input logic [63:0] old);
    int w = wide ? 64 : 32;
    int n;
    logic [63:0] s = src;
    if (!wide) s = {32'h0, src[31:0]};
    case (op)
      2'd0, 2'd1: begin
        if (s == 0) return {old, 1'b1, 1'b0};
        n = 0;
        if (op == 2'd1) begin
          while (s > 64'd1) begin s = s >> 1; n++; end
        end else begin
          while (s[0] == 1'b0) begin s = s >> 1; n++; end
        end
        return {64'(n), 1'b0, 1'b0};
      end
      default: begin
        n = 0;
        if (op == 2'd2) begin
          while (n < w && s[w-1-n] == 1'b0) n++;
        end else begin
          while (n < w && s[n] == 1'b0) n++;
        end
        return {64'(n), n == 0, n == w};
      end
    endcase
  endfunction

  task automatic check(input string req, input logic [65:0] exp);
    logic [65:0] act = {newDest, zeroFlag, carryFlag};
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual dest=%h zf=%b cf=%b expected dest=%h zf=%b cf=%b",
               req, act[65:2], act[1], act[0], exp[65:2], exp[1], exp[0]);
    end
  endtask

  // Issue one operation at a falling edge, check at the next falling edge.
  task automatic runOp(input string req, input logic [1:0] op, input logic wide,
                       input logic [63:0] src, input logic [63:0] old);
    opCode = op; isWide = wide; srcVal = src; oldDest = old; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check(req, model(op, wide, src, old));
  endtask

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      failCount++; checkCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
      $finish;
    end
  end

  initial begin
    logic [65:0] held;
    void'($urandom(32'd7));
    rst = 1'b1; inValid = 1'b0; opCode = 0; isWide = 1; srcVal = 0; oldDest = 0;
    @(negedge clk); @(negedge clk);
    // Drive valid during reset: reset must win.
    inValid = 1'b1; opCode = 2'd1; srcVal = 64'h80; oldDest = '1;
    @(negedge clk);
    check("R10 reset", 66'h0);
    rst = 1'b0; inValid = 1'b0;
    @(negedge clk);

    // Directed corners
    runOp("R2 hi scan of 1", 2'd1, 1'b1, 64'h1, 64'hDEAD);
    runOp("R2 hi scan bit63", 2'd1, 1'b1, 64'h8000_0000_0000_0001, 0);
    runOp("R3 lo scan", 2'd0, 1'b1, 64'h8000_0000_0000_0000, 0);
    runOp("R3 lo scan mixed", 2'd0, 1'b1, 64'h0000_0100_0000_0000, 0);
    runOp("R5 scan zero 32b keeps all ones", 2'd0, 1'b0, 64'h0, '1);
    runOp("R5 scan zero 64b keeps old", 2'd1, 1'b1, 64'h0, 64'h1234_5678_9ABC_DEF0);
    runOp("R1 R5 upper bits ignored in 32b scan", 2'd1, 1'b0, 64'hFFFF_FFFF_0000_0000, 64'hA5A5_A5A5_5A5A_5A5A);
    runOp("R4 32b scan zero-extends", 2'd1, 1'b0, 64'h0000_0000_8000_0000, '1);
    runOp("R6 lead count zero 64b", 2'd2, 1'b1, 64'h0, '1);
    runOp("R6 lead count zero 32b", 2'd2, 1'b0, 64'hFFFF_FFFF_0000_0000, '1);
    runOp("R6 R8 lead count zf", 2'd2, 1'b1, 64'h8000_0000_0000_0000, '1);
    runOp("R6 lead count 32b bit31", 2'd2, 1'b0, 64'h0000_0000_8000_0000, 0);
    runOp("R7 trail count zero 32b", 2'd3, 1'b0, 64'h0, 64'h5555);
    runOp("R7 R8 trail count bit0", 2'd3, 1'b1, 64'h1, '1);
    runOp("R7 trail count bit63", 2'd3, 1'b1, 64'h8000_0000_0000_0000, 0);

    // R9: idle cycles with changing inputs leave outputs alone
    held = {newDest, zeroFlag, carryFlag};
    opCode = 2'd2; isWide = 1'b0; srcVal = 64'h1; oldDest = 64'h77;
    @(negedge clk);
    check("R9 hold while idle", held);
    srcVal = 64'h0; opCode = 2'd0;
    @(negedge clk);
    check("R9 hold while idle again", held);

    // Random mix
    for (int k = 0; k < 400; k++) begin
      logic [1:0]  op   = 2'($urandom);
      logic        wide = 1'($urandom);
      logic [63:0] src  = {$urandom, $urandom};
      logic [63:0] old  = {$urandom, $urandom};
      int sh = $urandom % 64;
      case ($urandom % 4)
        0: src = 64'h0;
        1: src = 64'h1 << sh;
        2: src = src >> sh;
        default: ;
      endcase
      runOp("R1 R2 R3 R4 R5 R6 R7 R8 random", op, wide, src, old);
    end

    finished = 1;
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

endmodule